// File: doc/BRIEF.md
# Line-Range and Output-Band Gain Scheduler

This block picks, once per controller sample, which proportional/integral gain pair a digital voltage-loop compensator of a boost power-factor front end should use. Two independent classifications drive the choice. The first decides whether the supply is in the low mains range (roughly 90 to 132 V rms) or the high mains range (roughly 180 to 264 V rms). It does this by tracking the peak of the sensed rectified input over each half line cycle and applying hysteresis between the two range limits. The second compares the instantaneous output-voltage code with a window centred on the 385 V setpoint. Whenever the output leaves that window, the high-bandwidth (transient) pair for the current line range is used. As soon as the output is back inside, the low-bandwidth (steady) pair returns.

The gains are fixed constants: steady/low 2000 and 4133, transient/low 5867 and 20213, steady/high 627 and 2160, transient/high 3067 and 10566. Every threshold is an ADC code computed from volts as floor(V × 6.9e-3 / 3.3 × 4095). With that formula the window runs from 3193 (373 V) to 3399 (397 V). The range limits are peak codes 1592 (132 V rms) and 2174 (180 V rms).

The selector is a four-state machine:
- ST_LO_SS: low range, steady.
- ST_LO_TR: low range, transient.
- ST_HI_SS: high range, steady.
- ST_HI_TR: high range, transient.

On each accepted sample it follows exactly one transition. It may stay put, enter or leave transient within its range, or cross range (optionally also changing band) at a half-cycle end.

The half-cycle tracker has its own two states:
- HC_WAIT: waiting for the input to rise.
- HC_ARMED: a sample of at least code 128 has been seen.

It moves from HC_WAIT to HC_ARMED when that happens. It moves from HC_ARMED back to HC_WAIT on the first sample below code 64, and that sample is the half-cycle end.

Top module: `line_band_gain_sel`

## Requirements
- R1: During and after reset, with no sample accepted, the outputs show low range and steady mode: kp_out=2000, ki_out=4133, fast_mode=0, line_high=0.
- R2: The gain outputs follow the flags: low/steady 2000/4133, low/transient 5867/20213, high/steady 627/2160, high/transient 3067/10566. Here line_high=1 means high range and fast_mode=1 means transient.
- R3: A sample with vout_code below 3193 or above 3399 selects transient mode.
- R4: A sample with vout_code from 3193 to 3399 inclusive selects steady mode, so ripple of ±4 V (±34 codes) around 3296 never selects transient.
- R5: An accepted sample (smp_vld=1 at a rising edge) updates the outputs at that edge. They are therefore visible in the following cycle.
- R6: A half-cycle ends on an accepted sample with vin_code below 64, provided that since the previous end an accepted sample of 128 or more has been seen. The half-cycle peak is the largest vin_code accepted since the previous end.
- R7: At a half-cycle end, a peak above 2174 selects high range and a peak below 1592 selects low range. A peak from 1592 to 2174 inclusive keeps the current range.
- R8: With smp_vld=0, no output changes, whatever vin_code and vout_code carry.
- R9: A sample below 64 that is not preceded by a sample of 128 or more since the last end does not end a half-cycle and leaves the range unchanged.
- R10: The line range changes only on a half-cycle end sample, never during a half-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new sample pair is present this cycle |
| vin_code | input | 12 | ADC code of the rectified line voltage |
| vout_code | input | 12 | ADC code of the output voltage |
| kp_out | output | 16 | Selected proportional gain |
| ki_out | output | 16 | Selected integral gain |
| fast_mode | output | 1 | 1 while the transient gain pair is selected |
| line_high | output | 1 | 1 while the high line range is selected |

## Verification
The properties assume that both codes are stable and meaningful whenever smp_vld is high. They also assume that the rectified input really dips below the end threshold once per half line cycle after climbing above the arming level. The stimulus keeps within this by building each half-cycle as a rising and falling staircase that ends in a near-zero sample. Output codes are placed on, just inside and just outside both window edges. Line peaks are placed on and beside both hysteresis limits. One idle stretch carries out-of-range values with smp_vld low to show that they are not taken.

// File: rtl/lbg_pkg.sv
package lbg_pkg;

    localparam int GAIN_W = 16;

    typedef enum logic [1:0] {
        ST_LO_SS = 2'b00,
        ST_LO_TR = 2'b01,
        ST_HI_SS = 2'b10,
        ST_HI_TR = 2'b11
    } lbg_state_e;

    typedef enum logic {
        HC_WAIT  = 1'b0,
        HC_ARMED = 1'b1
    } hc_state_e;

    typedef struct packed {
        logic [GAIN_W-1:0] kp;
        logic [GAIN_W-1:0] ki;
    } gain_pair_t;

    // Sensed volts -> ADC code, divider gain given in parts per million.
    function automatic longint volts_to_code(input int volts, input int div_ppm,
                                             input int vref_mv, input int adc_w);
        longint full_scale;
        full_scale = (longint'(1) <<< adc_w) - 1;
        return (longint'(volts) * longint'(div_ppm) * full_scale) /
               (longint'(vref_mv) * 1000);
    endfunction

    // Sinusoidal rms -> peak, truncated to whole volts.
    function automatic int rms_to_peak(input int vrms);
        return (vrms * 1414) / 1000;
    endfunction

endpackage

// File: rtl/lbg_peak_track.sv
module lbg_peak_track #(
    parameter int ADC_W     = 12,
    parameter int ZERO_CODE = 64,
    parameter int ARM_CODE  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [ADC_W-1:0] vin,
    output logic             hc_end,
    output logic [ADC_W-1:0] hc_peak
);
    import lbg_pkg::*;

    localparam logic [ADC_W-1:0] ZERO_C = ADC_W'(ZERO_CODE);
    localparam logic [ADC_W-1:0] ARM_C  = ADC_W'(ARM_CODE);

    hc_state_e        hc_st, hc_st_n;
    logic [ADC_W-1:0] peak_q, peak_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_st  <= HC_WAIT;
            peak_q <= '0;
        end else begin
            hc_st  <= hc_st_n;
            peak_q <= peak_n;
        end
    end

    always_comb begin
        hc_st_n = hc_st;
        peak_n  = peak_q;
        hc_end  = 1'b0;
        if (smp_vld) begin
            unique case (hc_st)
                HC_WAIT: begin
                    if (vin > peak_q) peak_n = vin;
                    if (vin >= ARM_C) hc_st_n = HC_ARMED;
                end
                HC_ARMED: begin
                    if (vin < ZERO_C) begin
                        hc_end  = 1'b1;
                        hc_st_n = HC_WAIT;
                        peak_n  = '0;
                    end else if (vin > peak_q) begin
                        peak_n = vin;
                    end
                end
            endcase
        end
    end

    assign hc_peak = peak_q;

endmodule

// File: rtl/lbg_band_win.sv
module lbg_band_win #(
    parameter int               ADC_W = 12,
    parameter logic [ADC_W-1:0] LO_C  = '0,
    parameter logic [ADC_W-1:0] HI_C  = '1
) (
    input  logic [ADC_W-1:0] vout,
    output logic             below,
    output logic             above
);
    always_comb begin
        below = (vout < LO_C);
        above = (vout > HI_C);
    end
endmodule

// File: rtl/lbg_gain_lut.sv
module lbg_gain_lut #(
    parameter int KP_LO_SS = 2000,
    parameter int KI_LO_SS = 4133,
    parameter int KP_LO_TR = 5867,
    parameter int KI_LO_TR = 20213,
    parameter int KP_HI_SS = 627,
    parameter int KI_HI_SS = 2160,
    parameter int KP_HI_TR = 3067,
    parameter int KI_HI_TR = 10566
) (
    input  lbg_pkg::lbg_state_e st,
    output lbg_pkg::gain_pair_t gains
);
    import lbg_pkg::*;

    always_comb begin
        unique case (st)
            ST_LO_SS: gains = '{kp: GAIN_W'(KP_LO_SS), ki: GAIN_W'(KI_LO_SS)};
            ST_LO_TR: gains = '{kp: GAIN_W'(KP_LO_TR), ki: GAIN_W'(KI_LO_TR)};
            ST_HI_SS: gains = '{kp: GAIN_W'(KP_HI_SS), ki: GAIN_W'(KI_HI_SS)};
            ST_HI_TR: gains = '{kp: GAIN_W'(KP_HI_TR), ki: GAIN_W'(KI_HI_TR)};
        endcase
    end
endmodule

// File: rtl/line_band_gain_sel.sv
module line_band_gain_sel #(
    parameter int ADC_W        = 12,
    parameter int V_NOM        = 385,
    parameter int V_HALF_BAND  = 12,
    parameter int VRMS_LO_TOP  = 132,
    parameter int VRMS_HI_BOT  = 180,
    parameter int DIV_PPM      = 6900,
    parameter int VREF_MV      = 3300,
    parameter int ZERO_CODE    = 64,
    parameter int ARM_CODE     = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_vld,
    input  logic [ADC_W-1:0]          vin_code,
    input  logic [ADC_W-1:0]          vout_code,
    output logic [lbg_pkg::GAIN_W-1:0] kp_out,
    output logic [lbg_pkg::GAIN_W-1:0] ki_out,
    output logic                      fast_mode,
    output logic                      line_high
);
    import lbg_pkg::*;

    localparam logic [ADC_W-1:0] BAND_LO = ADC_W'(volts_to_code(V_NOM - V_HALF_BAND, DIV_PPM, VREF_MV, ADC_W));
    localparam logic [ADC_W-1:0] BAND_HI = ADC_W'(volts_to_code(V_NOM + V_HALF_BAND, DIV_PPM, VREF_MV, ADC_W));
    localparam logic [ADC_W-1:0] PK_LO   = ADC_W'(volts_to_code(rms_to_peak(VRMS_LO_TOP), DIV_PPM, VREF_MV, ADC_W));
    localparam logic [ADC_W-1:0] PK_HI   = ADC_W'(volts_to_code(rms_to_peak(VRMS_HI_BOT), DIV_PPM, VREF_MV, ADC_W));

    lbg_state_e       st, st_n;
    logic             hc_end;
    logic [ADC_W-1:0] hc_peak;
    logic             out_below, out_above, out_of_band;
    logic             hi_now, hi_nxt;
    gain_pair_t       gains;

    lbg_peak_track #(
        .ADC_W     (ADC_W),
        .ZERO_CODE (ZERO_CODE),
        .ARM_CODE  (ARM_CODE)
    ) u_peak (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .vin     (vin_code),
        .hc_end  (hc_end),
        .hc_peak (hc_peak)
    );

    lbg_band_win #(
        .ADC_W (ADC_W),
        .LO_C  (BAND_LO),
        .HI_C  (BAND_HI)
    ) u_band (
        .vout  (vout_code),
        .below (out_below),
        .above (out_above)
    );

    lbg_gain_lut u_lut (
        .st    (st),
        .gains (gains)
    );

    assign out_of_band = out_below | out_above;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_LO_SS;
        else        st <= st_n;
    end

    // Line-range decision with hysteresis, only at a half-cycle end
    always_comb begin
        hi_now = (st == ST_HI_SS) || (st == ST_HI_TR);
        hi_nxt = hi_now;
        if (hc_end) begin
            if (hc_peak > PK_HI)      hi_nxt = 1'b1;
            else if (hc_peak < PK_LO) hi_nxt = 1'b0;
        end
    end

    // Next state
    always_comb begin
        st_n = st;
        if (smp_vld) begin
            unique case (st)
                ST_LO_SS: begin
                    if (hi_nxt)           st_n = out_of_band ? ST_HI_TR : ST_HI_SS; // range up
                    else if (out_of_band) st_n = ST_LO_TR;                          // leave band
                end
                ST_LO_TR: begin
                    if (hi_nxt)            st_n = out_of_band ? ST_HI_TR : ST_HI_SS;
                    else if (!out_of_band) st_n = ST_LO_SS;                         // re-enter band
                end
                ST_HI_SS: begin
                    if (!hi_nxt)          st_n = out_of_band ? ST_LO_TR : ST_LO_SS; // range down
                    else if (out_of_band) st_n = ST_HI_TR;
                end
                ST_HI_TR: begin
                    if (!hi_nxt)           st_n = out_of_band ? ST_LO_TR : ST_LO_SS;
                    else if (!out_of_band) st_n = ST_HI_SS;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        kp_out = gains.kp;
        ki_out = gains.ki;
        unique case (st)
            ST_LO_SS: begin fast_mode = 1'b0; line_high = 1'b0; end
            ST_LO_TR: begin fast_mode = 1'b1; line_high = 1'b0; end
            ST_HI_SS: begin fast_mode = 1'b0; line_high = 1'b1; end
            ST_HI_TR: begin fast_mode = 1'b1; line_high = 1'b1; end
        endcase
    end

endmodule

// File: rtl/lbg_chk.sv
module lbg_chk #(
    parameter int               ADC_W     = 12,
    parameter logic [ADC_W-1:0] BAND_LO   = '0,
    parameter logic [ADC_W-1:0] BAND_HI   = '1,
    parameter int               ZERO_CODE = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       smp_vld,
    input logic [ADC_W-1:0]           vin_code,
    input logic [ADC_W-1:0]           vout_code,
    input logic [lbg_pkg::GAIN_W-1:0] kp_out,
    input logic [lbg_pkg::GAIN_W-1:0] ki_out,
    input logic                       fast_mode,
    input logic                       line_high
);
    localparam logic [ADC_W-1:0] ZERO_C = ADC_W'(ZERO_CODE);

    // R3: out-of-window sample selects transient
    p_leave_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && ((vout_code < BAND_LO) || (vout_code > BAND_HI)) |=> fast_mode);

    // R4: in-window sample selects steady
    p_in_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && (vout_code >= BAND_LO) && (vout_code <= BAND_HI) |=> !fast_mode);

    // R8: idle cycles change nothing
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(kp_out) && $stable(ki_out) && $stable(fast_mode) && $stable(line_high));

    // R10: range moves only on a low-input sample
    p_range_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && (vin_code >= ZERO_C) |=> $stable(line_high));

    // R2: gain pair agrees with the flags
    p_gain_lo_ss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_high && !fast_mode |-> kp_out == 16'd2000 && ki_out == 16'd4133);
    p_gain_lo_tr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_high && fast_mode |-> kp_out == 16'd5867 && ki_out == 16'd20213);
    p_gain_hi_ss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_high && !fast_mode |-> kp_out == 16'd627 && ki_out == 16'd2160);
    p_gain_hi_tr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_high && fast_mode |-> kp_out == 16'd3067 && ki_out == 16'd10566);

    // R1: first cycle after reset shows the default selection
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> !line_high && !fast_mode);

endmodule

bind line_band_gain_sel lbg_chk #(
    .ADC_W     (ADC_W),
    .BAND_LO   (BAND_LO),
    .BAND_HI   (BAND_HI),
    .ZERO_CODE (ZERO_CODE)
) u_chk (.*);

// File: tb/tb_line_band_gain_sel.sv
module tb_line_band_gain_sel;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] kp;
        logic [15:0] ki;
        logic        fast;
        logic        high;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] vin_code = '0;
    logic [11:0] vout_code = '0;
    logic [15:0] kp_out, ki_out;
    logic        fast_mode, line_high;
    logic        vld_seen = 1'b0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  reported = 1'b0;
    exp_t exp_q[$];

    // independent reference state
    bit m_high = 1'b0;
    bit m_fast = 1'b0;
    bit m_armed = 1'b0;
    int m_peak = 0;

    line_band_gain_sel dut (
        .clk, .rst_n, .smp_vld, .vin_code, .vout_code,
        .kp_out, .ki_out, .fast_mode, .line_high
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) vld_seen <= smp_vld;

    function automatic exp_t mk_exp(bit high, bit fast, string tag);
        exp_t e;
        e.high = high; e.fast = fast; e.tag = tag;
        case ({high, fast})
            2'b00: begin e.kp = 16'd2000; e.ki = 16'd4133;  end
            2'b01: begin e.kp = 16'd5867; e.ki = 16'd20213; end
            2'b10: begin e.kp = 16'd627;  e.ki = 16'd2160;  end
            default: begin e.kp = 16'd3067; e.ki = 16'd10566; end
        endcase
        return e;
    endfunction

    task automatic compare(exp_t e);
        n_chk++;
        if (kp_out !== e.kp || ki_out !== e.ki || fast_mode !== e.fast || line_high !== e.high) begin
            n_fail++;
            $display("FAIL %s: got kp=%0d ki=%0d fast=%0b high=%0b, expected kp=%0d ki=%0d fast=%0b high=%0b",
                     e.tag, kp_out, ki_out, fast_mode, line_high, e.kp, e.ki, e.fast, e.high);
        end
    endtask

    // monitor: one expected item per accepted sample
    always @(negedge clk) begin
        if (vld_seen && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            compare(e);
        end
    end

    // driver: one accepted sample, expected result pushed
    task automatic drive(int vin, int vout, string tag);
        @(negedge clk);
        smp_vld   = 1'b1;
        vin_code  = 12'(vin);
        vout_code = 12'(vout);
        if (m_armed && vin < 64) begin
            if (m_peak > 2174)      m_high = 1'b1;
            else if (m_peak < 1592) m_high = 1'b0;
            m_armed = 1'b0;
            m_peak  = 0;
        end else begin
            if (vin >= 128)    m_armed = 1'b1;
            if (vin > m_peak)  m_peak = vin;
        end
        m_fast = (vout < 3193) || (vout > 3399);
        exp_q.push_back(mk_exp(m_high, m_fast, tag));
    endtask

    task automatic half_cycle(int pk, int vout, string tag);
        drive(pk / 4, vout, tag);
        drive(pk / 2, vout, tag);
        drive(pk,     vout, tag);
        drive(pk / 2, vout, tag);
        drive(pk / 4, vout, tag);
        drive(20,     vout, tag);
    endtask

    task automatic idle_check(int vin, int vout, string tag);
        @(negedge clk);
        smp_vld   = 1'b0;
        vin_code  = 12'(vin);
        vout_code = 12'(vout);
        repeat (3) @(negedge clk);
        compare(mk_exp(m_high, m_fast, tag));
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(mk_exp(1'b0, 1'b0, "R1 in reset"));
        rst_n = 1'b1;
        @(negedge clk);
        compare(mk_exp(1'b0, 1'b0, "R1 after reset"));

        // low line, output on setpoint and with ripple
        half_cycle(1400, 3296, "R2 low steady");
        drive(700, 3262, "R4 ripple low");
        drive(700, 3330, "R4 ripple high");

        // window edges, one-sample latency
        drive(800, 3193, "R4 lower edge");
        drive(800, 3192, "R3 below window");
        drive(800, 3399, "R4 upper edge");
        drive(800, 3400, "R3 above window");
        drive(800, 3296, "R5 back in band next cycle");

        // idle with out-of-band values
        idle_check(20, 3000, "R8 idle ignored");

        // range up: still low until the end sample
        half_cycle(2400, 3296, "R10 range up");
        drive(20, 3296, "R9 unarmed low sample");
        drive(30, 3296, "R9 unarmed low sample");
        drive(1000, 3420, "R2 high transient");
        drive(1000, 3296, "R2 high steady");

        // hysteresis and limits
        half_cycle(2000, 3296, "R7 between limits holds high");
        half_cycle(1592, 3296, "R7 peak 1592 holds high");
        half_cycle(1591, 3296, "R7 peak 1591 drops low");
        half_cycle(2174, 3296, "R7 peak 2174 holds low");
        half_cycle(2175, 3100, "R7 peak 2175 raises, transient");
        drive(600, 3296, "R6 new half-cycle steady");
        idle_check(3000, 3500, "R8 idle ignored high");

        @(negedge clk);
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        report();
        $finish;
    end
endmodule